// File: doc/BRIEF.md
# Single-Dword Memory-Write Packet Builder

This block turns one 32-bit write (an address and a data value) into a transaction-layer memory-write packet. The packet is presented as four 32-bit words on a valid/ready stream: three header words, then the payload word. A one-cycle start strobe loads the address, data, requester identifier and tag into internal registers. The block then streams the four words, holding each word steady while the sink applies backpressure. A busy output tells the requester when a new write can be launched.

Header words leave the block with their bytes reversed relative to their logical big-endian value. The payload word is passed through in its original order. The packet always describes a 32-bit-addressed write of length one dword. All four bytes of the dword are enabled, and no bytes are enabled in the last dword. The sink is assumed to sit on a link whose endpoint command register and base address have already been set up.

Top module: `mwr_tlp_gen`

## Requirements
- R1: After reset, `tx_valid_o` and `busy_o` are both low.
- R2: The first word of every packet is 0x01000040 on the bus (logical 0x40000001: format 3'b010 in bits 31:29, type 5'b00000 in bits 28:24, length 1 in bits 9:0, byte-reversed), and `tx_sop_o` is high with it.
- R3: The second word is the byte reversal of {requester ID[15:0], tag[7:0], last byte enable 4'h0, first byte enable 4'hF}; with ID 0 and tag 0 it reads 0x0F000000.
- R4: The third word is the byte reversal of the address with bits 1:0 forced to zero; address 0x30000000 is sent as 0x00000030.
- R5: The fourth word is the data value in its original byte order, and `tx_eop_o` is high with it.
- R6: `tx_sop_o` is high only on the first word and `tx_eop_o` only on the fourth. A packet has exactly four words.
- R7: While `tx_valid_o` is high and `tx_ready_i` is low, the word and its markers stay unchanged in the next cycle.
- R8: A start strobe seen while `busy_o` is high is ignored. It adds no packet and does not alter the packet in flight.
- R9: An accepted start raises `busy_o` and `tx_valid_o` in the next cycle. `busy_o` falls in the cycle after the fourth word is accepted, and a start is then taken again.
- R10: The packet carries the input values present in the start cycle. Later changes on those inputs have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to build a packet |
| addr_i | input | 32 | Write address (dword aligned) |
| data_i | input | 32 | Write data |
| req_id_i | input | 16 | Requester identifier |
| tag_i | input | 8 | Transaction tag |
| busy_o | output | 1 | Packet in progress; starts are ignored |
| tx_valid_o | output | 1 | Stream word valid |
| tx_ready_i | input | 1 | Sink accepts the word this cycle |
| tx_data_o | output | 32 | Stream word |
| tx_sop_o | output | 1 | First word of the packet |
| tx_eop_o | output | 1 | Last word of the packet |

## Verification
The bench uses unaligned addresses and non-zero requester and tag values, so a packer that lets the low address bits through or misplaces a field produces a different third or second word. Sink backpressure is applied in a repeating pattern. A design that advances without a handshake would skip words, and one that lets the output change while stalled would corrupt a word. Starts issued mid-packet, and input changes right after a start, expose a design that reloads its registers while busy. Such a design would emit an extra packet or a mixed packet.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
   localparam int DWORD_W = 32;

   typedef logic [DWORD_W-1:0] dword_t;

   localparam logic [2:0] FMT_3DW_WITH_DATA = 3'b010;
   localparam logic [4:0] TYPE_MEM_ACCESS   = 5'b00000;
   localparam logic [3:0] BE_FIRST_FULL     = 4'hF;
   localparam logic [3:0] BE_LAST_NONE      = 4'h0;

   typedef struct packed {
      logic [2:0]  fmt;
      logic [4:0]  kind;
      logic [13:0] attr_zero;
      logic [9:0]  len_dw;
   } hdr_w0_t;

   typedef struct packed {
      logic [15:0] requester;
      logic [7:0]  tag;
      logic [3:0]  be_last;
      logic [3:0]  be_first;
   } hdr_w1_t;
endpackage

// File: rtl/mwr_dw_order.sv
module mwr_dw_order #(
   parameter int WORD_W   = 32,
   parameter bit BYTE_REV = 1'b1
) (
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   localparam int NBYTES = WORD_W / 8;

   if (WORD_W % 8 != 0) begin : g_bad_width
      $error("mwr_dw_order: WORD_W must be a whole number of bytes");
   end

   if (BYTE_REV) begin : g_rev
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         assign dout[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
      end
   end else begin : g_pass
      assign dout = din;
   end
endmodule

// File: rtl/mwr_hdr_pack.sv
module mwr_hdr_pack
   import mwr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int RID_W  = 16,
   parameter int TAG_W  = 8,
   parameter int LEN_DW = 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [RID_W-1:0]  req_id,
   input  logic [TAG_W-1:0]  tag,
   output dword_t            hdr0,
   output dword_t            hdr1,
   output dword_t            hdr2
);
   localparam int ALIGN_BITS = 2;

   if (ADDR_W != DWORD_W) begin : g_bad_addr
      $error("mwr_hdr_pack: only 32-bit addressing is packed");
   end
   if (RID_W != 16 || TAG_W != 8) begin : g_bad_ids
      $error("mwr_hdr_pack: requester must be 16 bits and tag 8 bits");
   end
   if (LEN_DW < 1 || LEN_DW > 1023) begin : g_bad_len
      $error("mwr_hdr_pack: LEN_DW out of range");
   end

   hdr_w0_t w0;
   hdr_w1_t w1;

   always_comb begin
      w0.fmt       = FMT_3DW_WITH_DATA;
      w0.kind      = TYPE_MEM_ACCESS;
      w0.attr_zero = '0;
      w0.len_dw    = 10'(LEN_DW);

      w1.requester = req_id;
      w1.tag       = tag;
      w1.be_last   = BE_LAST_NONE;
      w1.be_first  = BE_FIRST_FULL;
   end

   assign hdr0 = w0;
   assign hdr1 = w1;
   assign hdr2 = {addr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
endmodule

// File: rtl/mwr_seq.sv
module mwr_seq #(
   parameter int NUM_WORDS = 4,
   parameter int IDX_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ready,
   output logic             load,
   output logic             active,
   output logic [IDX_W-1:0] idx,
   output logic             first,
   output logic             last
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

   if (NUM_WORDS < 2 || (1 << IDX_W) < NUM_WORDS) begin : g_bad_idx
      $error("mwr_seq: IDX_W too narrow for NUM_WORDS");
   end

   logic accept;

   assign load   = start && !active;
   assign accept = active && ready;
   assign first  = active && (idx == '0);
   assign last   = active && (idx == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
      end else if (load) begin
         active <= 1'b1;
         idx    <= '0;
      end else if (accept) begin
         if (idx == LAST_IDX) begin
            active <= 1'b0;
            idx    <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mwr_tlp_gen.sv
module mwr_tlp_gen
   import mwr_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int DATA_W        = 32,
   parameter int RID_W         = 16,
   parameter int TAG_W         = 8,
   parameter bit HDR_BYTE_REV  = 1'b1,
   parameter bit DATA_BYTE_REV = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [RID_W-1:0]  req_id_i,
   input  logic [TAG_W-1:0]  tag_i,
   output logic              busy_o,
   output logic              tx_valid_o,
   input  logic              tx_ready_i,
   output logic [DATA_W-1:0] tx_data_o,
   output logic              tx_sop_o,
   output logic              tx_eop_o
);
   localparam int HDR_WORDS = 3;
   localparam int NUM_WORDS = HDR_WORDS + 1;
   localparam int IDX_W     = $clog2(NUM_WORDS);

   if (DATA_W != DWORD_W) begin : g_bad_data
      $error("mwr_tlp_gen: stream words are 32 bits");
   end

   logic              load, active, first, last;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [RID_W-1:0]  rid_q;
   logic [TAG_W-1:0]  tag_q;

   mwr_seq #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start_i), .ready(tx_ready_i),
      .load(load), .active(active), .idx(idx), .first(first), .last(last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         rid_q  <= '0;
         tag_q  <= '0;
      end else if (load) begin
         addr_q <= addr_i;
         data_q <= data_i;
         rid_q  <= req_id_i;
         tag_q  <= tag_i;
      end
   end

   dword_t logical [NUM_WORDS];
   dword_t wire_fmt [NUM_WORDS];

   mwr_hdr_pack #(.ADDR_W(ADDR_W), .RID_W(RID_W), .TAG_W(TAG_W), .LEN_DW(1)) u_pack (
      .addr(addr_q), .req_id(rid_q), .tag(tag_q),
      .hdr0(logical[0]), .hdr1(logical[1]), .hdr2(logical[2])
   );
   assign logical[HDR_WORDS] = data_q;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_order
      localparam bit REV = (w < HDR_WORDS) ? HDR_BYTE_REV : DATA_BYTE_REV;
      mwr_dw_order #(.WORD_W(DWORD_W), .BYTE_REV(REV)) u_ord (
         .din(logical[w]), .dout(wire_fmt[w])
      );
   end

   assign tx_valid_o = active;
   assign busy_o     = active;
   assign tx_data_o  = wire_fmt[idx];
   assign tx_sop_o   = first;
   assign tx_eop_o   = last;
endmodule

// File: rtl/mwr_tlp_gen_chk.sv
module mwr_tlp_gen_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start_i,
   input logic        busy_o,
   input logic        tx_valid_o,
   input logic        tx_ready_i,
   input logic [31:0] tx_data_o,
   input logic        tx_sop_o,
   input logic        tx_eop_o
);
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)
         && $stable(tx_sop_o) && $stable(tx_eop_o)); // R7

   AST_MARKER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_sop_o && tx_eop_o)); // R6

   AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o && tx_sop_o |-> tx_data_o == 32'h01000040); // R2

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o && tx_valid_o && tx_sop_o); // R9

   AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o && tx_ready_i && tx_eop_o |=> !busy_o); // R9

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i && !(tx_valid_o && tx_ready_i && tx_eop_o) |=> busy_o && !tx_sop_o
         || $past(tx_sop_o) && !$past(tx_ready_i)); // R8
endmodule

bind mwr_tlp_gen mwr_tlp_gen_chk u_chk (.*);

// File: tb/mwr_tlp_gen_test.sv
module mwr_tlp_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] addr_i = '0;
   logic [31:0] data_i = '0;
   logic [15:0] req_id_i = '0;
   logic [7:0]  tag_i = '0;
   logic        busy_o, tx_valid_o, tx_sop_o, tx_eop_o;
   logic        tx_ready_i = 1'b1;
   logic [31:0] tx_data_o;

   int n_chk = 0;
   int n_bad = 0;
   bit bp = 1'b0;
   int cyc = 0;
   bit done = 1'b0;

   logic [33:0] expq [$];

   always #10 clk = ~clk;

   mwr_tlp_gen uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
      .data_i(data_i), .req_id_i(req_id_i), .tag_i(tag_i), .busy_o(busy_o),
      .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
      .tx_sop_o(tx_sop_o), .tx_eop_o(tx_eop_o)
   );

   function automatic logic [31:0] brev(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   task automatic check(input string req, input logic [33:0] got, input logic [33:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // ready pattern driver
   initial forever begin
      @(posedge clk); #1;
      cyc++;
      tx_ready_i = !bp || ((cyc % 3) != 0);
   end

   task automatic send(input logic [31:0] a, input logic [31:0] d,
                       input logic [15:0] r, input logic [7:0] t);
      while (busy_o) begin @(posedge clk); #1; end
      start_i = 1'b1; addr_i = a; data_i = d; req_id_i = r; tag_i = t;
      expq.push_back({2'b10, 32'h01000040});                      // R2
      expq.push_back({2'b00, brev({r, t, 4'h0, 4'hF})});          // R3
      expq.push_back({2'b00, brev({a[31:2], 2'b00})});            // R4
      expq.push_back({2'b01, d});                                 // R5
      @(posedge clk); #1;
      start_i = 1'b0;
      // R10: scramble inputs after the start cycle
      addr_i = ~a; data_i = ~d; req_id_i = ~r; tag_i = ~t;
      check("R9 busy after start", {33'b0, busy_o}, 34'd1);
   endtask

   // monitor / scoreboard
   logic        p_valid = 1'b0, p_ready = 1'b0;
   logic [33:0] p_word = '0;
   bit          eop_seen = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (eop_seen) begin
            check("R9 busy released", {33'b0, busy_o}, 34'd0);
            eop_seen = 1'b0;
         end
         if (p_valid && !p_ready)
            check("R7 stall hold", {tx_valid_o, tx_sop_o, tx_data_o}, {1'b1, p_word[33], p_word[31:0]});
         if (tx_valid_o && tx_ready_i) begin
            if (expq.size() == 0) begin
               check("R8 unexpected word", {tx_sop_o, tx_eop_o, tx_data_o}, 34'h3_FFFF_FFFF);
            end else begin
               logic [33:0] e;
               e = expq.pop_front();
               check("R6 R2-R5 word", {tx_sop_o, tx_eop_o, tx_data_o}, e);
               if (tx_eop_o) eop_seen = 1'b1;
            end
         end
         p_valid = tx_valid_o; p_ready = tx_ready_i;
         p_word  = {tx_sop_o, tx_eop_o, tx_data_o};
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         report();
      end
   end

   initial begin
      repeat (3) @(posedge clk); #1;
      check("R1 reset state", {32'b0, tx_valid_o, busy_o}, 34'd0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 idle after reset", {32'b0, tx_valid_o, busy_o}, 34'd0);

      send(32'h3000_0000, 32'h55AA_AA55, 16'h0000, 8'h00);
      send(32'h1234_5677, 32'hDEAD_BEEF, 16'hBEEF, 8'h5A);
      send(32'hFFFF_FFFE, 32'h0000_0001, 16'h0102, 8'hFF);

      // R8: start while busy must be ignored
      send(32'hA5A5_0004, 32'h1111_2222, 16'h4321, 8'h11);
      start_i = 1'b1; addr_i = 32'h0BAD_0000; data_i = 32'h0BAD_0BAD;
      @(posedge clk); #1;
      start_i = 1'b0;

      bp = 1'b1;
      for (int i = 0; i < 6; i++)
         send(32'h0000_1000 * i + 32'(i), 32'h0101_0101 * i, 16'(i * 257), 8'(i * 17));
      start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      bp = 1'b0;

      while (busy_o || expq.size() != 0) begin @(posedge clk); #1; end
      repeat (5) @(posedge clk); #1;
      check("R8 no extra packet", {33'b0, tx_valid_o}, 34'd0);
      check("R6 queue drained", 34'(expq.size()), 34'd0);
      done = 1'b1;
      report();
   end
endmodule